// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial PHY out of reset and then waits until the PHY's receive PLL reports lock. It does not touch the PHY's control port itself. Instead it drives a separate register-access master, which owns the handshake to the PHY's internal register space. Each request names one operation: capture an internal address, post a write, or read. The master answers address and read requests with a completion pulse, a failure flag and, for reads, the data.

After a start pulse the sequencer first captures the PHY's clock/reset register address. It then posts a write with the reset bit set. The PHY cannot acknowledge this write while it resets, so the sequencer does not wait for a completion. Next it runs a bounded polling loop. Each poll waits a programmable number of cycles, captures the address of the lane-0 output status register, and reads it. The sequence ends in one of three ways: the PLL lock bit is seen set, the poll budget runs out, or an access fails. The outcome is given as a one-cycle completion pulse with a sticky two-bit result code.

Top module: `phy_lock_seq`

## Requirements
- R1: While and after reset, with no start, `busy_o`, `done_o` and `acc_req_o` are 0 and `err_o` is 2'b00.
- R2: A start pulse in idle makes the first request a capture-address operation (`acc_op_o` = 2'b00) with `acc_wdata_o` = 16'h7F3F. The request is held until `acc_done_i`.
- R3: The reset write is a posted operation (`acc_op_o` = 2'b01) with `acc_wdata_o` bit 0 set. It is requested for exactly one cycle, and no completion is awaited.
- R4: Before every poll, `acc_req_o` stays low for max(`poll_delay_i`, 1) cycles.
- R5: Each poll captures address 16'h2003 (op 2'b00) and then issues a read (op 2'b10).
- R6: When a read returns with bit 1 of `acc_rdata_i` set, the sequence ends with result 2'b00 and no further accesses.
- R7: After 10 reads without the lock bit, the sequence ends with result 2'b10 (lock timeout). Exactly 10 reads are made.
- R8: A completion with `acc_fail_i` set on any address or read access ends the sequence at once with result 2'b01 (access failure). No further request follows.
- R9: `done_o` is a single-cycle pulse in the first cycle with `busy_o` low. `err_o` keeps its value until the next accepted start, which clears it to 2'b00.
- R10: A start pulse while `busy_o` is high has no effect on the access sequence or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| poll_delay_i | input | 16 | Cycles to wait before each poll |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Result: 00 ok, 01 access failure, 10 lock timeout |
| acc_req_o | output | 1 | Request to the access master |
| acc_op_o | output | 2 | 00 capture address, 01 posted write, 10 read |
| acc_wdata_o | output | 16 | Address or write value for the request |
| acc_done_i | input | 1 | Completion of an address or read request |
| acc_fail_i | input | 1 | Completion reports failure |
| acc_rdata_i | input | 16 | Read value, valid with completion |

## Verification
A request is visible on the cycle after the edge that consumes a start or a completion. The posted write lasts exactly one cycle. The low stretch of `acc_req_o` before a poll is therefore exactly the programmed delay, floored at one. `done_o` and the result code appear on the cycle after the edge that consumes the final completion. The bench drives completions with a random latency of zero to three cycles on the falling edge. It samples every output on the falling edge, measures each low stretch of the request while busy against the delay formula, and compares the result code and the number of accesses against values worked out from the injected lock position and failure index.

// File: rtl/pls_pkg.sv
package pls_pkg;
  typedef enum logic [1:0] {
    OP_ADDR = 2'd0,
    OP_POST = 2'd1,
    OP_READ = 2'd2
  } acc_op_t;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_ACCESS = 2'd1,
    RES_LOCK   = 2'd2
  } result_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST_ADDR,
    S_RST_WR,
    S_WAIT,
    S_POLL_ADDR,
    S_POLL_RD
  } seq_state_t;

  // Value loaded into the delay counter so that the wait lasts max(d,1) cycles
  function automatic logic [31:0] wait_load(input logic [31:0] d);
    return (d == 32'd0) ? 32'd0 : d - 32'd1;
  endfunction
endpackage

// File: rtl/pls_delay_timer.sv
module pls_delay_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             tick_i,
  output logic             expired_o
);
  import pls_pkg::*;

  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= DLY_W'(wait_load(32'(dly_i)));
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  // R4: a running countdown only ever steps down by one
  a_r4_countdown_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i && !expired_o) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/pls_poll_ctr.sv
module pls_poll_ctr #(
  parameter int MAX_POLLS = 10,
  localparam int PW = $clog2(MAX_POLLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [PW-1:0] cnt_o,
  output logic          last_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (inc_i && cnt_o != PW'(MAX_POLLS)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  assign last_o = (cnt_o == PW'(MAX_POLLS - 1));

  // R7: the number of failed polls never passes the budget
  a_r7_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= PW'(MAX_POLLS));
endmodule

// File: rtl/pls_fsm.sv
module pls_fsm #(
  parameter int          DW       = 16,
  parameter logic [15:0] RST_REG  = 16'h7F3F,
  parameter logic [15:0] RST_VAL  = 16'h0001,
  parameter logic [15:0] STAT_REG = 16'h2003
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          lock_i,
  input  logic          acc_done_i,
  input  logic          acc_fail_i,
  input  logic          expired_i,
  input  logic          last_i,
  output logic          load_o,
  output logic          tick_o,
  output logic          clr_o,
  output logic          inc_o,
  output logic          acc_req_o,
  output logic [1:0]    acc_op_o,
  output logic [DW-1:0] acc_wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    err_o
);
  import pls_pkg::*;

  seq_state_t state_q, state_d;
  logic       fin;
  result_t    fin_code;
  result_t    err_q;
  logic       accept;

  assign accept = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d     = state_q;
    fin         = 1'b0;
    fin_code    = RES_OK;
    load_o      = 1'b0;
    tick_o      = 1'b0;
    clr_o       = 1'b0;
    inc_o       = 1'b0;
    acc_req_o   = 1'b0;
    acc_op_o    = OP_ADDR;
    acc_wdata_o = '0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = S_RST_ADDR;
          clr_o   = 1'b1;
        end
      end
      S_RST_ADDR: begin
        acc_req_o   = 1'b1;
        acc_wdata_o = DW'(RST_REG);
        if (acc_done_i) begin
          if (acc_fail_i) begin
            fin = 1'b1; fin_code = RES_ACCESS; state_d = S_IDLE;
          end else begin
            state_d = S_RST_WR;
          end
        end
      end
      S_RST_WR: begin
        acc_req_o   = 1'b1;
        acc_op_o    = OP_POST;
        acc_wdata_o = DW'(RST_VAL);
        load_o      = 1'b1;
        state_d     = S_WAIT;
      end
      S_WAIT: begin
        if (expired_i) state_d = S_POLL_ADDR;
        else           tick_o  = 1'b1;
      end
      S_POLL_ADDR: begin
        acc_req_o   = 1'b1;
        acc_wdata_o = DW'(STAT_REG);
        if (acc_done_i) begin
          if (acc_fail_i) begin
            fin = 1'b1; fin_code = RES_ACCESS; state_d = S_IDLE;
          end else begin
            state_d = S_POLL_RD;
          end
        end
      end
      S_POLL_RD: begin
        acc_req_o = 1'b1;
        acc_op_o  = OP_READ;
        if (acc_done_i) begin
          if (acc_fail_i) begin
            fin = 1'b1; fin_code = RES_ACCESS; state_d = S_IDLE;
          end else if (lock_i) begin
            fin = 1'b1; fin_code = RES_OK; state_d = S_IDLE;
          end else begin
            inc_o = 1'b1;
            if (last_i) begin
              fin = 1'b1; fin_code = RES_LOCK; state_d = S_IDLE;
            end else begin
              load_o  = 1'b1;
              state_d = S_WAIT;
            end
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_o  <= 1'b0;
      err_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      done_o  <= fin;
      if (accept)   err_q <= RES_OK;
      else if (fin) err_q <= fin_code;
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign err_o  = err_q;

  // R9: completion pulse marks the first idle cycle
  a_r9_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  // R9: result code is stable while idle without a start
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i && !done_o) |=> $stable(err_o));
  // R3: posted reset write lasts one cycle
  a_r3_post_single: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req_o && acc_op_o == OP_POST) |=> !(acc_req_o && acc_op_o == OP_POST));
  // R2: an acknowledged request is held stable until its completion
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req_o && acc_op_o != OP_POST && !acc_done_i) |=>
      (acc_req_o && $stable(acc_op_o) && $stable(acc_wdata_o)));
  // R8: a failed completion ends the run on the next cycle
  a_r8_fail_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req_o && acc_op_o != OP_POST && acc_done_i && acc_fail_i) |=>
      (done_o && err_o == RES_ACCESS && !acc_req_o));
  // R4: the wait state is left only once the timer has expired
  a_r4_no_early_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && !expired_i) |=> (state_q == S_WAIT));
  // R10: start is not accepted while busy
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && state_q != S_POLL_RD && state_q != S_RST_ADDR
     && state_q != S_POLL_ADDR) |=> busy_o);
endmodule

// File: rtl/phy_lock_seq.sv
module phy_lock_seq #(
  parameter int          DW        = 16,
  parameter int          DLY_W     = 16,
  parameter int          MAX_POLLS = 10,
  parameter int          LOCK_BIT  = 1,
  parameter logic [15:0] RST_REG   = 16'h7F3F,
  parameter logic [15:0] RST_VAL   = 16'h0001,
  parameter logic [15:0] STAT_REG  = 16'h2003,
  localparam int         PW        = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DLY_W-1:0] poll_delay_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       err_o,
  output logic             acc_req_o,
  output logic [1:0]       acc_op_o,
  output logic [DW-1:0]    acc_wdata_o,
  input  logic             acc_done_i,
  input  logic             acc_fail_i,
  input  logic [DW-1:0]    acc_rdata_i
);
  import pls_pkg::*;

  logic          tmr_load, tmr_tick, tmr_expired;
  logic          poll_clr, poll_inc, poll_last;
  logic [PW-1:0] poll_cnt;
  logic          lock_seen;

  assign lock_seen = acc_rdata_i[LOCK_BIT];

  pls_delay_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .dly_i(poll_delay_i),
    .tick_i(tmr_tick), .expired_o(tmr_expired)
  );

  pls_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_polls (
    .clk(clk), .rst_n(rst_n), .clr_i(poll_clr), .inc_i(poll_inc),
    .cnt_o(poll_cnt), .last_o(poll_last)
  );

  pls_fsm #(
    .DW(DW), .RST_REG(RST_REG), .RST_VAL(RST_VAL), .STAT_REG(STAT_REG)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lock_i(lock_seen),
    .acc_done_i(acc_done_i), .acc_fail_i(acc_fail_i),
    .expired_i(tmr_expired), .last_i(poll_last),
    .load_o(tmr_load), .tick_o(tmr_tick), .clr_o(poll_clr), .inc_o(poll_inc),
    .acc_req_o(acc_req_o), .acc_op_o(acc_op_o), .acc_wdata_o(acc_wdata_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  // R7: a lock timeout is reported only once the whole budget is spent
  a_r7_timeout_full: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == RES_LOCK) |-> (poll_cnt == PW'(MAX_POLLS)));
  // R6: success is reported only with polls left in the budget
  a_r6_ok_in_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == RES_OK) |-> (poll_cnt < PW'(MAX_POLLS)));
endmodule

// File: tb/phy_lock_seq_tb.sv
module phy_lock_seq_tb;
  localparam int MAXP = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] poll_delay_i = '0;
  logic        busy_o, done_o, acc_req_o;
  logic [1:0]  err_o, acc_op_o;
  logic [15:0] acc_wdata_o;
  logic        acc_done_i = 1'b0;
  logic        acc_fail_i = 1'b0;
  logic [15:0] acc_rdata_i = '0;

  always #10 clk = ~clk;

  phy_lock_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .poll_delay_i(poll_delay_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .acc_req_o(acc_req_o), .acc_op_o(acc_op_o), .acc_wdata_o(acc_wdata_o),
    .acc_done_i(acc_done_i), .acc_fail_i(acc_fail_i), .acc_rdata_i(acc_rdata_i)
  );

  int checks = 0;
  int fails  = 0;
  int lock_at, fail_at, exp_wait;
  int acks, reads, posts, low_run, lat;
  bit pend;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_wait_len(input int d);
    return (d < 1) ? 1 : d;
  endfunction

  // access master model: drives on the falling edge
  initial begin
    pend = 0; lat = 0; low_run = 0;
    forever begin
      @(negedge clk);
      acc_done_i = 1'b0;
      acc_fail_i = 1'b0;
      if (busy_o) begin
        if (!acc_req_o) low_run++;
        else if (low_run > 0) begin
          chk(low_run == exp_wait, "R4", low_run, exp_wait);
          low_run = 0;
        end
      end else low_run = 0;
      if (acc_req_o && acc_op_o == 2'b01) begin
        posts++;
        chk(acc_wdata_o[0] == 1'b1, "R3", acc_wdata_o, 1);
      end else if (acc_req_o) begin
        if (!pend) begin pend = 1; lat = $urandom_range(0, 3); end
        if (lat == 0) begin
          pend = 0;
          if (acks == 0) begin
            chk(acc_op_o == 2'b00 && acc_wdata_o == 16'h7F3F, "R2",
                acc_wdata_o, 16'h7F3F);
          end else if (acks % 2 == 1) begin
            chk(acc_op_o == 2'b00 && acc_wdata_o == 16'h2003, "R5",
                acc_wdata_o, 16'h2003);
          end else begin
            chk(acc_op_o == 2'b10, "R5", acc_op_o, 2);
          end
          if (acc_op_o == 2'b10) begin
            reads++;
            acc_rdata_i = 16'($urandom) & 16'hFFFD;
            if (reads == lock_at) acc_rdata_i = acc_rdata_i | 16'h0002;
          end
          acc_fail_i = (acks == fail_at);
          acc_done_i = 1'b1;
          acks++;
        end else lat--;
      end
    end
  end

  task automatic run(input int d, input int la, input int fa, input bit poke);
    int np, total, exp_acks, exp_code, cyc;
    lock_at = la; fail_at = fa; exp_wait = exp_wait_len(d);
    acks = 0; reads = 0; posts = 0;
    np = (la >= 1 && la <= MAXP) ? la : MAXP;
    total = 1 + 2 * np;
    if (fa >= 0 && fa < total) begin exp_acks = fa + 1; exp_code = 1; end
    else begin exp_acks = total; exp_code = (la >= 1 && la <= MAXP) ? 0 : 2; end
    @(negedge clk);
    poll_delay_i = 16'(d);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1 && err_o == 2'b00, "R9", {busy_o, err_o}, 3'b100);
    if (poke) begin
      repeat (2) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!done_o && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(done_o == 1'b1 && busy_o == 1'b0, "R9", {done_o, busy_o}, 2'b10);
    chk(err_o == 2'(exp_code), exp_code == 1 ? "R8" : (exp_code == 2 ? "R7" : "R6"),
        err_o, exp_code);
    chk(acks == exp_acks, poke ? "R10" : "R8", acks, exp_acks);
    chk(reads == (exp_acks - 1) / 2, exp_code == 2 ? "R7" : "R5", reads, (exp_acks - 1) / 2);
    chk(posts == ((fa == 0) ? 0 : 1), "R3", posts, (fa == 0) ? 0 : 1);
    @(negedge clk);
    chk(done_o == 1'b0 && err_o == 2'(exp_code) && !acc_req_o, "R9",
        {done_o, err_o}, exp_code);
    repeat (3) @(negedge clk);
    chk(err_o == 2'(exp_code) && acks == exp_acks, "R9", err_o, exp_code);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !acc_req_o && err_o == 2'b00, "R1",
        {busy_o, done_o, acc_req_o, err_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !acc_req_o && err_o == 2'b00, "R1",
        {busy_o, done_o, acc_req_o, err_o}, 0);
    // directed corner cases
    run(0, 1, -1, 0);     // R4 zero delay, R6 lock on first poll
    run(5, 10, -1, 0);    // R6 lock on the last allowed poll
    run(3, 0, -1, 0);     // R7 never locks
    run(2, 11, -1, 0);    // R7 lock would come too late
    run(4, 3, 0, 0);      // R8 reset address fails
    run(1, 0, 20, 0);     // R8 final read fails
    run(2, 4, 3, 0);      // R8 poll address fails
    run(6, 5, -1, 1);     // R10 start while busy
    for (int i = 0; i < 24; i++) begin
      int d, la, fa;
      d  = $urandom_range(0, 20);
      la = $urandom_range(0, 11);
      fa = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 21) : -1;
      run(d, la, fa, (fa < 0) && ($urandom_range(0, 1) == 1));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule